// File: doc/BRIEF.md
# Fractional-Step PWM Generator with Staged Reconfiguration

This block drives one pulse-width modulated output from a single 32-bit control register. A phase accumulator of `STEP_W` bits adds a programmable step on every clock while the output is enabled. Each time the accumulator wraps, a new output cycle begins, so the output frequency is step × f_clk / 2^STEP_W. The upper eight bits of the accumulator are compared against an 8-bit off-time threshold. A larger threshold gives a shorter high time, and the high fraction of each cycle is roughly (255 − threshold)/255.

Software writes a new step and threshold into a shadow copy, together with an update-request flag. The active copy takes the shadow values only at the next cycle start, and only while the flag is set. Hardware clears the flag in the same clock edge that loads the new values, so software polls the flag to learn when the change has landed. This means period and duty never change in the middle of a cycle.

A write that arrives while a request is still pending does not touch the staged configuration. The enable bit remains writable at all times. Turning the output off and back on therefore forces a cycle start, and a request that is stuck behind a zero step can still complete.

Top module: `phacc_pwm`

## Requirements
- R1: After reset, the read value is all zeros and `pwm_o` is low.
- R2: The register layout is: bit 31 enable, bit 30 update request, step at bits [8+STEP_W-1:8], and off-time threshold at bits [7:0]. All other bits read as zero, and reads show the shadow step and threshold.
- R3: A write accepted with bit 30 clear changes only the shadow copy. Output period and duty keep their active values.
- R4: When bit 30 is set, the active step and threshold load from the shadow at the next cycle start. In that same clock edge, bit 30 reads back as 0.
- R5: While bit 30 reads 1, a write leaves step, threshold and bit 30 unchanged, but bit 31 still takes the written value.
- R6: While enabled, the accumulator advances by the active step each clock and wraps modulo 2^STEP_W. A carry out of the accumulator is a cycle start, giving one output cycle every 2^STEP_W/step clocks.
- R7: `pwm_o` is high exactly when enable is 1 and the accumulator's top 8 bits are strictly greater than the active threshold.
- R8: With an active step of 0, the accumulator holds and no cycle start occurs, so a pending request stays pending.
- R9: With enable at 0, the accumulator is held at zero and `pwm_o` is low. The first clock edge with enable at 1 after it was 0 counts as a cycle start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read value, including the live update-request flag |
| pwm_o | output | 1 | PWM output |

## Verification
A stale active copy, or a request flag that clears at the wrong edge, changes the duty pattern on `pwm_o` within one output cycle. It also moves the cycle in which bit 30 drops, so both faults are observed within 2^STEP_W/step clocks of the request. A write that leaks through while a request is pending appears in the very next read of the register. A wrong accumulator or carry shifts the comparator pattern on the first clock it occurs. The bench therefore compares both outputs against a reference model on every cycle.

// File: rtl/phacc_pkg.sv
package phacc_pkg;
  localparam int REG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int UPD_BIT  = 30;
  localparam int THR_W    = 8;
  localparam int STEP_LSB = 8;
  localparam int STEP_MAX = UPD_BIT - STEP_LSB;  // widest step field that fits
endpackage

// File: rtl/phacc_regs.sv
module phacc_regs
  import phacc_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              cyc_start_i,
  output logic              en_o,
  output logic              upd_o,
  output logic [STEP_W-1:0] sh_step_o,
  output logic [THR_W-1:0]  sh_thr_o,
  output logic [REG_W-1:0]  rd_data_o
);
  logic              en_q, upd_q;
  logic [STEP_W-1:0] step_q;
  logic [THR_W-1:0]  thr_q;
  logic              wr_ok;

  assign wr_ok = wr_en_i && !upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      upd_q  <= 1'b0;
      step_q <= '0;
      thr_q  <= '0;
    end else begin
      // enable stays writable so a stalled request can be forced through
      if (wr_en_i) en_q <= wr_data_i[EN_BIT];
      if (wr_ok) begin
        upd_q  <= wr_data_i[UPD_BIT];
        step_q <= wr_data_i[STEP_LSB +: STEP_W];
        thr_q  <= wr_data_i[THR_W-1:0];
      end else if (cyc_start_i && upd_q) begin
        upd_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[EN_BIT]              = en_q;
    rd_data_o[UPD_BIT]             = upd_q;
    rd_data_o[STEP_LSB +: STEP_W]  = step_q;
    rd_data_o[THR_W-1:0]           = thr_q;
  end

  assign en_o      = en_q;
  assign upd_o     = upd_q;
  assign sh_step_o = step_q;
  assign sh_thr_o  = thr_q;

  assert_upd_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && upd_q) |=> !upd_q);

  assert_pend_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q && wr_en_i) |=> ($stable(step_q) && $stable(thr_q)));
endmodule

// File: rtl/phacc_core.sv
module phacc_core
  import phacc_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              upd_i,
  input  logic [STEP_W-1:0] sh_step_i,
  input  logic [THR_W-1:0]  sh_thr_i,
  output logic [STEP_W-1:0] acc_o,
  output logic [THR_W-1:0]  act_thr_o,
  output logic              cyc_start_o
);
  logic [STEP_W-1:0] acc_q, act_step_q;
  logic [THR_W-1:0]  act_thr_q;
  logic              en_d_q;
  logic [STEP_W:0]   sum;
  logic              load;

  assign sum         = {1'b0, acc_q} + {1'b0, act_step_q};
  assign cyc_start_o = en_i && (!en_d_q || sum[STEP_W]);
  assign load        = cyc_start_o && upd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      act_step_q <= '0;
      act_thr_q  <= '0;
      en_d_q     <= 1'b0;
    end else begin
      en_d_q <= en_i;
      acc_q  <= en_i ? sum[STEP_W-1:0] : '0;
      if (load) begin
        act_step_q <= sh_step_i;
        act_thr_q  <= sh_thr_i;
      end
    end
  end

  assign acc_o     = acc_q;
  assign act_thr_o = act_thr_q;

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));

  assert_zero_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_d_q && act_step_q == '0) |=> $stable(acc_q));

  assert_active_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(act_step_q) && $stable(act_thr_q)));
endmodule

// File: rtl/phacc_cmp.sv
module phacc_cmp
  import phacc_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              en_i,
  input  logic [STEP_W-1:0] acc_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              pwm_o
);
  logic [THR_W-1:0] phase_hi;

  assign phase_hi = acc_i[STEP_W-1 -: THR_W];
  assign pwm_o    = en_i && (phase_hi > thr_i);
endmodule

// File: rtl/phacc_pwm.sv
module phacc_pwm
  import phacc_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  logic              en, upd, cyc_start;
  logic [STEP_W-1:0] sh_step, acc;
  logic [THR_W-1:0]  sh_thr, act_thr;

  initial begin
    assert_step_w_R2: assert (STEP_W >= THR_W && STEP_W <= STEP_MAX);
  end

  phacc_regs #(.STEP_W(STEP_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cyc_start_i(cyc_start),
    .en_o       (en),
    .upd_o      (upd),
    .sh_step_o  (sh_step),
    .sh_thr_o   (sh_thr),
    .rd_data_o  (rd_data_o)
  );

  phacc_core #(.STEP_W(STEP_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .upd_i      (upd),
    .sh_step_i  (sh_step),
    .sh_thr_i   (sh_thr),
    .acc_o      (acc),
    .act_thr_o  (act_thr),
    .cyc_start_o(cyc_start)
  );

  phacc_cmp #(.STEP_W(STEP_W)) u_cmp (
    .en_i (en),
    .acc_i(acc),
    .thr_i(act_thr),
    .pwm_o(pwm_o)
  );

  assert_off_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[EN_BIT] |-> !pwm_o);
endmodule

// File: tb/sim_phacc_pwm.sv
module sim_phacc_pwm;
  localparam int B = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd;
  logic        pwm;

  int total = 0;
  int bad   = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  phacc_pwm #(.STEP_W(B)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .pwm_o(pwm)
  );

  // reference model built from the requirements
  logic         m_en, m_upd, m_en_d;
  logic [B-1:0] m_sstep, m_astep, m_acc;
  logic [7:0]   m_sthr, m_athr;
  logic [B:0]   m_sum;
  logic         m_cs, m_en_old, m_upd_old;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_upd = 0; m_en_d = 0;
      m_sstep = '0; m_astep = '0; m_acc = '0; m_sthr = '0; m_athr = '0;
    end else begin
      m_en_old  = m_en;
      m_upd_old = m_upd;
      m_sum = {1'b0, m_acc} + {1'b0, m_astep};
      m_cs  = m_en_old && (!m_en_d || m_sum[B]);                 // R6 R9
      m_acc = m_en_old ? m_sum[B-1:0] : '0;
      if (m_cs && m_upd_old) begin                               // R4
        m_astep = m_sstep; m_athr = m_sthr; m_upd = 1'b0;
      end
      if (wr_en) m_en = wr_data[31];                             // R5
      if (wr_en && !m_upd_old) begin                             // R3
        m_upd = wr_data[30]; m_sstep = wr_data[8 +: B]; m_sthr = wr_data[7:0];
      end
      m_en_d = m_en_old;
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[31] = m_en; r[30] = m_upd; r[8 +: B] = m_sstep; r[7:0] = m_sthr;
    return r;
  endfunction

  function automatic logic exp_pwm();
    return m_en && (m_acc[B-1 -: 8] > m_athr);
  endfunction

  function automatic logic [31:0] mk(bit en, bit upd, int step, int thr);
    logic [31:0] r = '0;
    r[31] = en; r[30] = upd; r[8 +: B] = step[B-1:0]; r[7:0] = thr[7:0];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check("R7", {31'b0, pwm}, {31'b0, exp_pwm()});
      check("R2", rd, exp_rd());
    end
  end

  task automatic wr(logic [31:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) c++;
    end
  endtask

  task automatic wait_clear();
    for (int i = 0; i < 64 && rd[30]; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd, 32'h0);
    check("R1", {31'b0, pwm}, 32'h0);
    chk_on = 1'b1;

    // R2: unused bits read zero
    wr(32'h3F12_345A);
    check("R2", rd, 32'h0012_345A);

    // R9 + R4: enable with request applies on first enabled edge
    wr(mk(1, 1, 8192, 100));
    check("R4", {31'b0, rd[30]}, 32'h1);
    @(negedge clk);
    check("R9", {31'b0, rd[30]}, 32'h0);
    repeat (2) @(negedge clk);
    count_high(8, c);
    check("R6", c, 4);  // top bits 0,32..224 ; >100 -> 4 of 8

    // R3: shadow only
    wr(mk(1, 0, 8192, 200));
    check("R3", {24'b0, rd[7:0]}, 32'd200);
    count_high(8, c);
    check("R3", c, 4);
    wr(mk(1, 1, 8192, 200));
    wait_clear();
    repeat (2) @(negedge clk);
    count_high(8, c);
    check("R4", c, 1);

    // R5: write during pending request is dropped
    wr(mk(1, 1, 4096, 0));
    wr(mk(1, 0, 4096, 50));
    check("R5", {24'b0, rd[7:0]}, 32'd0);
    wait_clear();

    // R8: zero step stalls a request until enable toggles
    wr(mk(1, 1, 0, 10));
    wait_clear();
    wr(mk(1, 1, 8192, 100));
    repeat (40) @(negedge clk);
    check("R8", {31'b0, rd[30]}, 32'h1);
    wr(32'h0);
    check("R5", rd, mk(0, 1, 8192, 100));
    check("R9", {31'b0, pwm}, 32'h0);
    wr(32'h8000_0000);
    check("R9", {31'b0, rd[30]}, 32'h1);
    @(negedge clk);
    check("R9", {31'b0, rd[30]}, 32'h0);

    // random traffic against the model
    for (int i = 0; i < 15000; i++) begin
      if ($urandom % 4 == 0) begin
        int st, sel;
        sel = $urandom % 4;
        st  = (sel == 0) ? 0 : (sel == 1) ? (1 << ($urandom % B)) : int'($urandom);
        wr_data = mk(($urandom % 8) != 0, $urandom % 2, st, $urandom);
        wr_data[29:8+B] = $urandom;  // R2 unused bits
        wr_en = 1'b1;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    finish_run();
  end
endmodule